// File: doc/BRIEF.md
# Bit-Serial Main Memory Port

This block is the path between a bit-serial processor core and its main store. The store is a single-bit-wide array addressed by a flat bit index. The low part of that index is the processor's shared bit counter, which sweeps every bit position of a word once per word time. The high part is a word address. The control logic shifts the word address in one bit at a time from one of its circulating register tracks, then moves it into a holding latch with a strobe at the end of a word. The address then stays fixed for the whole next sweep of the bit counter.

Each clock, the port reads exactly one bit, the bit at the held word address and the current bit count. That bit shows up on the read output after the clock edge. When the write enable is high, the same cycle also replaces that bit with the write data bit. Deciding when an instruction fetches or stores is left to the surrounding control logic. This block only guarantees where each bit goes and when it comes back.

The word-address width is a parameter. The full-size machine uses 12 bits, giving 4096 words of 32 bits (128 Kbit in total). The default build uses 7 bits (128 words, 4096 bits) so that it elaborates quickly. The bit counter is 5 bits wide, giving 32 bits per word.

Top module: `bitser_mem_port`

## Requirements
- R1: After each rising clock edge, `rd_bit` holds the stored bit at the word address and the `bit_cnt` value that were present at that edge. This gives one bit per clock with one cycle of latency.
- R2: A write (`wr_en` high at an edge) changes only the single bit addressed at that edge. Every other bit of every word keeps its value.
- R3: When a write and the read happen at the same location in the same cycle, `rd_bit` returns the value stored before the write.
- R4: The address shift register moves only on edges where `addr_load_en` is high. It then shifts toward its most significant bit and takes `addr_ser_in` into bit 0, so the word address is entered most significant bit first. On edges where `addr_load_en` is low, `addr_ser_in` has no effect.
- R5: A strobe (`addr_strobe` high) on an edge where `bit_cnt` equals all ones (31) copies the shift register into the word-address latch. The new address applies from the next edge onward, which is bit 0 of the following word.
- R6: A strobe on an edge where `bit_cnt` is not all ones is ignored, and the word address keeps its value.
- R7: Between two accepted strobes, the word address does not change, so all 32 bits of a word are accessed at one address.
- R8: Reset (`rst_n` low, asynchronous) clears the word address, the shift register and `rd_bit` to 0. The stored array is not cleared.
- R9: The flat bit index is the word address times 32 plus `bit_cnt`, so words never overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_cnt | input | 5 | Shared bit counter, the bit position within the word |
| addr_ser_in | input | 1 | Serial word-address bit from a register track |
| addr_load_en | input | 1 | Shift-register enable for `addr_ser_in` |
| addr_strobe | input | 1 | Request to move the shifted address into the latch |
| wr_en | input | 1 | Write the current bit |
| wr_bit | input | 1 | Data bit to write |
| rd_bit | output | 1 | Data bit read, registered |

## Verification
The main function is driven with a table of words that have distinct addresses and dissimilar bit patterns. The addresses include the lowest non-zero word, the highest word and mid-range words with alternating bits. Reading back every word after all of them have been written tells a correct flat index apart from aliasing or a swapped bit order. A word that is rewritten while its old contents are checked bit by bit separates read-before-write from write-through. Strobes at a bit count other than 31, and serial data presented while the load enable is low, show whether the address latch and the shift register ignore input they should not act on. A reset in the middle of operation shows that accesses return to word 0 while the stored contents survive.

// File: rtl/bsm_pkg.sv
`timescale 1ns/1ps
package bsm_pkg;

  // Flat bit index of a word/bit pair for a store with 2**bit_w bits per word.
  function automatic int unsigned flat_bit_index(input int unsigned word_addr,
                                                 input int unsigned bit_pos,
                                                 input int unsigned bit_w);
    return (word_addr << bit_w) + bit_pos;
  endfunction

  // True when the bit counter sits on the last bit of a word.
  function automatic bit is_word_end(input int unsigned bit_pos,
                                     input int unsigned bit_w);
    return bit_pos == ((1 << bit_w) - 1);
  endfunction

endpackage

// File: rtl/bsm_addr_shift.sv
`timescale 1ns/1ps
module bsm_addr_shift #(
  parameter int ADDR_W = 7,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic              ser_in,
  input  logic              load_en,
  input  logic              strobe,
  output logic [ADDR_W-1:0] shift_q,
  output logic [ADDR_W-1:0] word_addr,
  output logic              shift_fire,
  output logic              latch_fire
);
  import bsm_pkg::*;

  logic at_word_end;

  assign at_word_end = is_word_end(int'(bit_cnt), BIT_W);
  assign shift_fire  = load_en;
  assign latch_fire  = strobe && at_word_end;

  // Serial-in register, most significant bit entered first.
  generate
    if (ADDR_W > 1) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          shift_q <= '0;
        else if (shift_fire) shift_q <= {shift_q[ADDR_W-2:0], ser_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          shift_q <= '0;
        else if (shift_fire) shift_q <= ser_in;
      end
    end
  endgenerate

  // Parallel holding latch, moved only at a word boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_addr <= '0;
    else if (latch_fire) word_addr <= shift_q;
  end

endmodule

// File: rtl/bsm_bit_store.sv
`timescale 1ns/1ps
module bsm_bit_store #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic             wr_bit,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wr_bit;
  end

  // The read samples the cell before any write in the same edge lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_bit <= 1'b0;
    else        rd_bit <= cells[idx];
  end

endmodule

// File: rtl/bitser_mem_port.sv
`timescale 1ns/1ps
module bitser_mem_port #(
  parameter int WORD_ADDR_W = 7,
  parameter int BIT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic             addr_ser_in,
  input  logic             addr_load_en,
  input  logic             addr_strobe,
  input  logic             wr_en,
  input  logic             wr_bit,
  output logic             rd_bit
);
  import bsm_pkg::*;

  localparam int IDX_W = WORD_ADDR_W + BIT_W;

  logic [WORD_ADDR_W-1:0] shift_q;
  logic [WORD_ADDR_W-1:0] word_addr;
  logic                   shift_fire;
  logic                   latch_fire;
  logic                   wr_fire;
  logic [IDX_W-1:0]       mem_idx;

  assign mem_idx = IDX_W'(flat_bit_index(int'(word_addr), int'(bit_cnt), BIT_W));
  assign wr_fire = wr_en;

  bsm_addr_shift #(
    .ADDR_W (WORD_ADDR_W),
    .BIT_W  (BIT_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_cnt    (bit_cnt),
    .ser_in     (addr_ser_in),
    .load_en    (addr_load_en),
    .strobe     (addr_strobe),
    .shift_q    (shift_q),
    .word_addr  (word_addr),
    .shift_fire (shift_fire),
    .latch_fire (latch_fire)
  );

  bsm_bit_store #(
    .IDX_W (IDX_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (mem_idx),
    .we     (wr_fire),
    .wr_bit (wr_bit),
    .rd_bit (rd_bit)
  );

endmodule

// File: rtl/bsm_port_checker.sv
`timescale 1ns/1ps
module bsm_port_checker #(
  parameter int WORD_ADDR_W = 7,
  parameter int BIT_W       = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [BIT_W-1:0]       bit_cnt,
  input logic                   addr_ser_in,
  input logic                   addr_load_en,
  input logic                   addr_strobe,
  input logic [WORD_ADDR_W-1:0] shift_q,
  input logic [WORD_ADDR_W-1:0] word_addr,
  input logic                   latch_fire
);
  localparam logic [BIT_W-1:0] LAST = '1;

  assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load_en |=> $stable(shift_q));

  assert_shift_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load_en |=> shift_q[0] == $past(addr_ser_in));

  assert_latch_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && bit_cnt == LAST) |=> word_addr == $past(shift_q));

  assert_strobe_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && bit_cnt != LAST) |=> $stable(word_addr));

  assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fire |=> $stable(word_addr));

  assert_reset_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_addr == '0 && shift_q == '0));

endmodule

bind bitser_mem_port bsm_port_checker #(
  .WORD_ADDR_W (WORD_ADDR_W),
  .BIT_W       (BIT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_cnt      (bit_cnt),
  .addr_ser_in  (addr_ser_in),
  .addr_load_en (addr_load_en),
  .addr_strobe  (addr_strobe),
  .shift_q      (shift_q),
  .word_addr    (word_addr),
  .latch_fire   (latch_fire)
);

// File: tb/sim_bitser_mem_port.sv
`timescale 1ns/1ps
module sim_bitser_mem_port;
  localparam int AW = 7;
  localparam int BW = 5;
  localparam int WB = 32;
  localparam int NV = 6;

  // {word address, data word}
  localparam logic [AW+WB-1:0] VEC [NV] = '{
    {7'd1,   32'hDEADBEEF},
    {7'd127, 32'h80000001},
    {7'd64,  32'h55AA33CC},
    {7'd2,   32'hFFFFFFFE},
    {7'd85,  32'h0F1E2D3C},
    {7'd42,  32'h7654A1B9}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] bit_cnt = '0;
  logic          addr_ser_in = 1'b0;
  logic          addr_load_en = 1'b0;
  logic          addr_strobe = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_bit = 1'b0;
  logic          rd_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitser_mem_port u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_cnt      (bit_cnt),
    .addr_ser_in  (addr_ser_in),
    .addr_load_en (addr_load_en),
    .addr_strobe  (addr_strobe),
    .wr_en        (wr_en),
    .wr_bit       (wr_bit),
    .rd_bit       (rd_bit)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One word time: bit_cnt sweeps 0..31. Optionally shift in an address
  // (MSB first in the first AW cycles), strobe at position stb_at,
  // write a data word and collect the read bits for comparison.
  task automatic do_word(input logic [AW-1:0] nxt, input bit ld, input int stb_at,
                         input bit wr, input logic [31:0] wd,
                         input bit chk, input logic [31:0] exp, input string req);
    logic [31:0] got;
    got = '0;
    for (int b = 0; b < WB; b++) begin
      bit_cnt      = BW'(b);
      wr_en        = wr;
      wr_bit       = wd[b];
      addr_load_en = ld && (b < AW);
      addr_ser_in  = (ld && b < AW) ? nxt[AW-1-b] : b[0];
      addr_strobe  = (b == stb_at);
      @(posedge clk);
      #1;
      got[b] = rd_bit;
    end
    wr_en = 1'b0; addr_load_en = 1'b0; addr_strobe = 1'b0;
    if (chk) check(got === exp, req, got, exp);
  endtask

  task automatic select(input logic [AW-1:0] a);
    do_word(a, 1'b1, WB-1, 1'b0, '0, 1'b0, '0, "");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(rd_bit === 1'b0, "R8 rd_bit at reset", {31'd0, rd_bit}, 32'd0);
    rst_n = 1'b1;

    // R8: after reset the word address is 0, so this write lands in word 0.
    do_word('0, 1'b0, -1, 1'b1, 32'hA5A50F0F, 1'b0, '0, "");

    // Table walk: write every word, then read every word back (R1 R2 R9).
    for (int i = 0; i < NV; i++) begin
      select(VEC[i][AW+WB-1:WB]);
      do_word('0, 1'b0, -1, 1'b1, VEC[i][WB-1:0], 1'b0, '0, "");
    end
    for (int i = 0; i < NV; i++) begin
      select(VEC[i][AW+WB-1:WB]);
      do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, VEC[i][WB-1:0], "R1 R2 R9 table readback");
    end
    select('0);
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'hA5A50F0F, "R8 word 0 after reset");

    // R3: rewrite word 1 while reading it; each bit returns the old value.
    select(7'd1);
    do_word('0, 1'b0, -1, 1'b1, 32'h12345678, 1'b1, 32'hDEADBEEF, "R3 read before write");
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'h12345678, "R3 new value stored");

    // R6: strobe mid-word with word 42 shifted in; the write stays in word 1.
    do_word(7'd42, 1'b1, 10, 1'b1, 32'hCAFE0001, 1'b0, '0, "");
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'hCAFE0001, "R6 mid-word strobe ignored");

    // R4 R5 R7: serial data with load enable low; strobe at bit 31 latches
    // the address shifted earlier (42). Word 1 stays selected during this word.
    do_word('0, 1'b0, WB-1, 1'b0, '0, 1'b1, 32'hCAFE0001, "R5 R7 old address until word end");
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'h7654A1B9, "R4 R5 shift held, latched 42");

    // R2: neighbouring word 2 untouched by all of the above.
    select(7'd2);
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'hFFFFFFFE, "R2 neighbour intact");

    // R8: reset in operation returns to word 0 and keeps the array.
    select(7'd64);
    #1; rst_n = 1'b0;
    @(posedge clk); #1;
    check(rd_bit === 1'b0, "R8 rd_bit cleared", {31'd0, rd_bit}, 32'd0);
    rst_n = 1'b1;
    do_word('0, 1'b0, -1, 1'b1, 32'h0BADF00D, 1'b0, '0, "");
    select('0);
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'h0BADF00D, "R8 address 0 after reset");
    select(7'd64);
    do_word('0, 1'b0, -1, 1'b0, '0, 1'b1, 32'h55AA33CC, "R8 array kept over reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule